// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache with two ways in every set. Each way of each set keeps a valid flag, a tag and one full data line. A client presents an address with a valid strobe. When one of the two ways of the indexed set holds a matching valid tag, the addressed word comes back on the next cycle with a hit flag. On a miss the block raises a busy flag and requests the whole line from a backing memory. It installs that line together with its tag in a chosen way and then answers with the requested word.

When a set has an empty way, the fill always goes there. When both ways are valid, the way to overwrite is chosen by a replacement policy fixed by a build parameter. The random policy uses one free-running toggle bit. The FIFO policy keeps one pointer bit per set. The LRU policy keeps one "used" bit per way. No policy needs more than one bit of state per set or per way.

Top module: `cache_2way`

## Requirements
- R1: After a synchronous reset, every line is invalid and busy, mem_req and rsp_valid are low. All policy bits are cleared: the toggle, the FIFO pointers and the USED bits.
- R2: The address is split from the top down into TAG_W tag bits, IDX_W set-index bits and OFF_W word-offset bits. The offset o selects the word in bits [o*WORD_W +: WORD_W] of the line.
- R3: A request in the idle state that matches a valid tag in either way of its set gives rsp_valid=1 and rsp_hit=1 on the next cycle, carrying the addressed word of the stored line. Back-to-back hits are accepted on consecutive cycles.
- R4: On a miss, busy and mem_req rise on the next cycle. mem_addr carries the line-aligned address (offset bits zero). mem_req and mem_addr stay unchanged until the cycle in which mem_ack is sampled high.
- R5: In the cycle after mem_ack, busy and mem_req are low and rsp_valid=1 with rsp_hit=0. The response carries the requested word taken from the line delivered on mem_line with the acknowledge.
- R6: A request presented while busy is high is ignored. It produces no response and installs nothing.
- R7: If both ways of the set are invalid, the fill goes to way 0. If exactly one way is invalid, the fill goes to that way. A valid line is never evicted while its set has an empty way.
- R8: A fill replaces the whole line and its tag in one way. A later hit on that line returns words of the newly delivered line.
- R9: Random policy: a toggle bit is 0 in the first cycle after reset and inverts on every clock. On a miss to a full set, the victim is the way equal to the toggle value in the cycle the missing request is presented.
- R10: FIFO policy: each set has one pointer bit. After any fill into way w of that set, including a fill into an empty way, the pointer names the other way. A miss to a full set evicts the way the pointer names.
- R11: LRU policy: every hit or fill of way w clears that way's USED bit and sets the USED bit of the other way of the same set.
- R12: LRU policy: a miss to a full set evicts the way whose USED bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | TAG_W+IDX_W+OFF_W | Read word address |
| rsp_valid | output | 1 | Response word valid |
| rsp_hit | output | 1 | Response was served from a stored line |
| rsp_data | output | WORD_W | Response word |
| busy | output | 1 | Refill in progress, requests ignored |
| mem_req | output | 1 | Line request to the backing memory |
| mem_addr | output | TAG_W+IDX_W+OFF_W | Line-aligned refill address |
| mem_ack | input | 1 | Backing memory acknowledge, line valid |
| mem_line | input | WORD_W<<OFF_W | Full line delivered with the acknowledge |

## Verification
A wrong valid bit or tag shows up on the very next request to that set. Instead of a one-cycle hit the port shows a busy flag and a refill request, or the reverse, a hit carrying stale words. A wrong policy bit stays hidden until a miss lands on a full set. It then shows as the wrong line surviving, which is seen on the next access to the evicted or kept address. The stimulus therefore forces conflict misses in a single set under each policy and probes both candidate lines right afterwards. A bench model runs every clock and catches the divergence on the first cycle where the busy flag, the hit flag or the returned word differs.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;

    typedef enum logic [1:0] {
        REPL_RANDOM = 2'd0,
        REPL_FIFO   = 2'd1,
        REPL_LRU    = 2'd2
    } repl_e;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_REFILL = 1'b1
    } ctrl_e;

    // Empty way first (way 0 before way 1), otherwise the policy's choice.
    function automatic logic pick_way(logic v0, logic v1, logic pol_way);
        if (!v0)      return 1'b0;
        else if (!v1) return 1'b1;
        else          return pol_way;
    endfunction

endpackage

// File: rtl/cache_store.sv
`timescale 1ns/1ps
module cache_store #(
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 2,
    parameter int LINE_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic                   wr_en,
    input  logic                   wr_way,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [TAG_W-1:0]       wr_tag,
    input  logic [LINE_W-1:0]      wr_line,
    output logic [1:0]             rd_valid,
    output logic [1:0][TAG_W-1:0]  rd_tag,
    output logic [1:0][LINE_W-1:0] rd_line
);
    localparam int SETS = 1 << IDX_W;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [SETS-1:0]   vld;
        logic [TAG_W-1:0]  tg [SETS];
        logic [LINE_W-1:0] ln [SETS];
        logic              sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk) begin
            if (rst)      vld         <= '0;
            else if (sel) vld[wr_idx] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tg[wr_idx] <= wr_tag;
                ln[wr_idx] <= wr_line;
            end
        end

        assign rd_valid[w] = vld[rd_idx];
        assign rd_tag[w]   = tg[rd_idx];
        assign rd_line[w]  = ln[rd_idx];
    end
endmodule

// File: rtl/cache_repl.sv
`timescale 1ns/1ps
module cache_repl
    import cache_pkg::*;
#(
    parameter repl_e POLICY = REPL_LRU,
    parameter int    IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             hit_en,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic             touch_way,
    output logic             pol_way
);
    localparam int SETS = 1 << IDX_W;

    if (POLICY == REPL_RANDOM) begin : g_rand
        logic tog;
        logic unused_rand;
        assign unused_rand = ^{sel_idx, hit_en, fill_en, touch_idx, touch_way};
        always_ff @(posedge clk) begin
            if (rst) tog <= 1'b0;
            else     tog <= ~tog;
        end
        assign pol_way = tog;
    end else if (POLICY == REPL_FIFO) begin : g_fifo
        logic [SETS-1:0] ptr;
        logic            unused_fifo;
        assign unused_fifo = hit_en;
        always_ff @(posedge clk) begin
            if (rst)          ptr            <= '0;
            else if (fill_en) ptr[touch_idx] <= ~touch_way;
        end
        assign pol_way = ptr[sel_idx];
    end else begin : g_lru
        logic [SETS-1:0] used0;
        logic [SETS-1:0] used1;
        always_ff @(posedge clk) begin
            if (rst) begin
                used0 <= '0;
                used1 <= '0;
            end else if (hit_en || fill_en) begin
                used0[touch_idx] <= touch_way;
                used1[touch_idx] <= ~touch_way;
            end
        end
        // A set USED bit on way 1 marks it as the victim; otherwise way 0.
        logic unused_lru;
        assign unused_lru = ^used0;
        assign pol_way = used1[sel_idx];
    end
endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/1ps
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 2,
    parameter int WORD_W = 8,
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W,
    localparam int LINE_W = WORD_W << OFF_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [1:0]             rd_valid,
    input  logic [1:0][TAG_W-1:0]  rd_tag,
    input  logic [1:0][LINE_W-1:0] rd_line,
    input  logic                   pol_way,
    input  logic                   mem_ack,
    input  logic [LINE_W-1:0]      mem_line,
    output logic [IDX_W-1:0]       lookup_idx,
    output logic                   wr_en,
    output logic                   wr_way,
    output logic [IDX_W-1:0]       wr_idx,
    output logic [TAG_W-1:0]       wr_tag,
    output logic [LINE_W-1:0]      wr_line,
    output logic                   hit_en,
    output logic                   fill_en,
    output logic [IDX_W-1:0]       touch_idx,
    output logic                   touch_way,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [WORD_W-1:0]      rsp_data,
    output logic                   busy,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr
);
    function automatic logic [WORD_W-1:0] word_at(logic [LINE_W-1:0] l, logic [OFF_W-1:0] o);
        return l[o*WORD_W +: WORD_W];
    endfunction

    ctrl_e            st;
    logic [TAG_W-1:0] pend_tag;
    logic [IDX_W-1:0] pend_idx;
    logic [OFF_W-1:0] pend_off;
    logic             pend_way;

    logic [TAG_W-1:0] r_tag;
    logic [IDX_W-1:0] r_idx;
    logic [OFF_W-1:0] r_off;
    logic [1:0]       hit_vec;
    logic             accept, hit, miss, fill, hit_way, victim;

    assign r_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign r_idx = req_addr[OFF_W +: IDX_W];
    assign r_off = req_addr[OFF_W-1:0];

    assign lookup_idx = (st == ST_LOOKUP) ? r_idx : pend_idx;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == r_tag);
    end

    assign accept  = (st == ST_LOOKUP) && req_valid;
    assign hit     = accept && (|hit_vec);
    assign miss    = accept && !(|hit_vec);
    assign hit_way = hit_vec[1];
    assign victim  = pick_way(rd_valid[0], rd_valid[1], pol_way);
    assign fill    = (st == ST_REFILL) && mem_ack;

    assign wr_en     = fill;
    assign wr_way    = pend_way;
    assign wr_idx    = pend_idx;
    assign wr_tag    = pend_tag;
    assign wr_line   = mem_line;
    assign hit_en    = hit;
    assign fill_en   = fill;
    assign touch_idx = fill ? pend_idx : r_idx;
    assign touch_way = fill ? pend_way : hit_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_LOOKUP;
            pend_tag  <= '0;
            pend_idx  <= '0;
            pend_off  <= '0;
            pend_way  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= hit || fill;
            rsp_hit   <= hit;
            if (hit)  rsp_data <= word_at(rd_line[hit_way], r_off);
            if (fill) rsp_data <= word_at(mem_line, pend_off);
            if (miss) begin
                st       <= ST_REFILL;
                pend_tag <= r_tag;
                pend_idx <= r_idx;
                pend_off <= r_off;
                pend_way <= victim;
            end else if (fill) begin
                st <= ST_LOOKUP;
            end
        end
    end

    assign busy     = (st == ST_REFILL);
    assign mem_req  = (st == ST_REFILL);
    assign mem_addr = {pend_tag, pend_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/cache_2way.sv
`timescale 1ns/1ps
module cache_2way
    import cache_pkg::*;
#(
    parameter int    TAG_W  = 6,
    parameter int    IDX_W  = 2,
    parameter int    OFF_W  = 2,
    parameter int    WORD_W = 8,
    parameter repl_e POLICY = REPL_LRU,
    localparam int   ADDR_W = TAG_W + IDX_W + OFF_W,
    localparam int   LINE_W = WORD_W << OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_data,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_line
);
    logic [IDX_W-1:0]       lookup_idx, wr_idx, touch_idx;
    logic                   wr_en, wr_way, hit_en, fill_en, touch_way, pol_way;
    logic [TAG_W-1:0]       wr_tag;
    logic [LINE_W-1:0]      wr_line;
    logic [1:0]             rd_valid;
    logic [1:0][TAG_W-1:0]  rd_tag;
    logic [1:0][LINE_W-1:0] rd_line;

    cache_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) store_i (
        .clk(clk), .rst(rst), .rd_idx(lookup_idx),
        .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(wr_line),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line)
    );

    cache_repl #(.POLICY(POLICY), .IDX_W(IDX_W)) repl_i (
        .clk(clk), .rst(rst), .sel_idx(lookup_idx),
        .hit_en(hit_en), .fill_en(fill_en), .touch_idx(touch_idx), .touch_way(touch_way),
        .pol_way(pol_way)
    );

    cache_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) ctrl_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line), .pol_way(pol_way),
        .mem_ack(mem_ack), .mem_line(mem_line),
        .lookup_idx(lookup_idx), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
        .wr_tag(wr_tag), .wr_line(wr_line), .hit_en(hit_en), .fill_en(fill_en),
        .touch_idx(touch_idx), .touch_way(touch_way),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr)
    );
endmodule

// File: rtl/cache_2way_chk.sv
`timescale 1ns/1ps
module cache_2way_chk #(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: outputs idle in the cycle right after reset
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            p_reset_idle_r1: assert (!busy && !mem_req && !rsp_valid)
                else $error("reset state not idle");
        end
    end

    p_refill_hold_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_line_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[OFF_W-1:0] == '0);

    p_miss_starts_r4: assert property (@(posedge clk) disable iff (rst)
        !busy && req_valid |=> rsp_hit || busy);

    p_fill_answer_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> rsp_valid && !rsp_hit && !busy && !mem_req);

    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rsp_valid);

    p_hit_valid_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);
endmodule

bind cache_2way cache_2way_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr)
);

// File: tb/cache_2way_tb_top.sv
`timescale 1ns/1ps
module cache_2way_tb_top;
    import cache_pkg::*;

    localparam int NP = 3;   // 0: LRU, 1: FIFO, 2: random

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [9:0] req_addr = '0;

    logic        rv [NP];
    logic        hit [NP];
    logic [7:0]  data [NP];
    logic        busy [NP];
    logic        mreq [NP];
    logic [9:0]  maddr [NP];
    logic        ack [NP];
    logic [31:0] mline [NP];

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 125 MHz

    cache_2way #(.POLICY(REPL_LRU)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv[0]), .rsp_hit(hit[0]), .rsp_data(data[0]), .busy(busy[0]),
        .mem_req(mreq[0]), .mem_addr(maddr[0]), .mem_ack(ack[0]), .mem_line(mline[0]));
    cache_2way #(.POLICY(REPL_FIFO)) dut_fifo_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv[1]), .rsp_hit(hit[1]), .rsp_data(data[1]), .busy(busy[1]),
        .mem_req(mreq[1]), .mem_addr(maddr[1]), .mem_ack(ack[1]), .mem_line(mline[1]));
    cache_2way #(.POLICY(REPL_RANDOM)) dut_rnd_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rv[2]), .rsp_hit(hit[2]), .rsp_data(data[2]), .busy(busy[2]),
        .mem_req(mreq[2]), .mem_addr(maddr[2]), .mem_ack(ack[2]), .mem_line(mline[2]));

    // ---------------- backing memory content ----------------
    function automatic logic [7:0] mem_word(logic [9:0] a, int k);
        int v;
        v = int'(a[9:2]) * 37 + k * 91 + 17;
        return 8'(v);
    endfunction

    function automatic logic [31:0] mem_line_of(logic [9:0] a);
        logic [31:0] l;
        for (int k = 0; k < 4; k++) l[k*8 +: 8] = mem_word(a, k);
        return l;
    endfunction

    function automatic logic [9:0] mk(int t, int i, int o);
        return {6'(t), 2'(i), 2'(o)};
    endfunction

    // ---------------- behavioural reference model ----------------
    bit       m_vld  [NP][2][4];
    int       m_tag  [NP][2][4];
    bit       m_used [NP][2][4];
    bit       m_ptr  [NP][4];
    bit       m_tog  [NP];
    bit       m_fill [NP];
    int       m_pidx [NP], m_ptag [NP], m_poff [NP], m_pway [NP];
    bit       ex_rv [NP], ex_hit [NP], ex_busy [NP];
    int       ex_data [NP];
    logic [9:0] ex_maddr [NP];
    int       ack_cnt [NP];
    bit       last_hit [NP];
    bit       stepped = 0;
    string    pol_tag [NP] = '{"R12", "R10", "R9"};

    task automatic touch(int p, int idx, int w, bit is_fill);
        if (p == 0) begin
            m_used[p][w][idx]   = 0;
            m_used[p][1-w][idx] = 1;
        end
        if (p == 1 && is_fill) m_ptr[p][idx] = (w == 0);
    endtask

    task automatic step(int p);
        int idx, tg, off, hw, vw;
        if (rst) begin
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < 4; s++) begin
                    m_vld[p][w][s] = 0;
                    m_used[p][w][s] = 0;
                end
            for (int s = 0; s < 4; s++) m_ptr[p][s] = 0;
            m_tog[p] = 0; m_fill[p] = 0;
            ex_rv[p] = 0; ex_hit[p] = 0; ex_busy[p] = 0;
            return;
        end
        ex_rv[p] = 0; ex_hit[p] = 0;
        if (!m_fill[p]) begin
            if (req_valid) begin
                tg = int'(req_addr[9:4]); idx = int'(req_addr[3:2]); off = int'(req_addr[1:0]);
                hw = -1;
                for (int w = 0; w < 2; w++)
                    if (m_vld[p][w][idx] && m_tag[p][w][idx] == tg) hw = w;
                if (hw >= 0) begin
                    ex_rv[p] = 1; ex_hit[p] = 1;
                    ex_data[p] = int'(mem_word(req_addr, off));
                    touch(p, idx, hw, 0);
                end else begin
                    if (!m_vld[p][0][idx])      vw = 0;
                    else if (!m_vld[p][1][idx]) vw = 1;
                    else if (p == 0)            vw = m_used[p][1][idx] ? 1 : 0;
                    else if (p == 1)            vw = int'(m_ptr[p][idx]);
                    else                        vw = int'(m_tog[p]);
                    m_fill[p] = 1;
                    m_pidx[p] = idx; m_ptag[p] = tg; m_poff[p] = off; m_pway[p] = vw;
                    ex_busy[p] = 1;
                    ex_maddr[p] = {req_addr[9:2], 2'b00};
                end
            end
        end else if (ack[p]) begin
            m_vld[p][m_pway[p]][m_pidx[p]] = 1;
            m_tag[p][m_pway[p]][m_pidx[p]] = m_ptag[p];
            touch(p, m_pidx[p], m_pway[p], 1);
            ex_rv[p] = 1;
            ex_data[p] = int'(mem_word(ex_maddr[p], m_poff[p]));
            m_fill[p] = 0; ex_busy[p] = 0;
        end
        m_tog[p] = ~m_tog[p];
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: act=%0d exp=%0d", req, $time, act, exp);
        end
    endtask

    // Compare, answer memory, then advance the model: once per clock, at the falling edge.
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (stepped) begin
                chk(busy[p] == ex_busy[p], rst ? "R1" : "R4 busy", int'(busy[p]), int'(ex_busy[p]));
                chk(mreq[p] == ex_busy[p], "R4 mem_req", int'(mreq[p]), int'(ex_busy[p]));
                chk(rv[p] == ex_rv[p], "R3/R5 rsp_valid", int'(rv[p]), int'(ex_rv[p]));
                chk(hit[p] == ex_hit[p], pol_tag[p], int'(hit[p]), int'(ex_hit[p]));
                if (ex_rv[p]) chk(int'(data[p]) == ex_data[p], "R2/R8 data", int'(data[p]), ex_data[p]);
                if (ex_busy[p]) chk(maddr[p] == ex_maddr[p], "R4 mem_addr", int'(maddr[p]), int'(ex_maddr[p]));
            end
            if (rv[p] === 1'b1) last_hit[p] = hit[p];
            if (mreq[p] === 1'b1) begin
                ack_cnt[p]++;
                ack[p]   = (ack_cnt[p] == 3);
                mline[p] = mem_line_of(maddr[p]);
            end else begin
                ack_cnt[p] = 0;
                ack[p] = 1'b0;
                mline[p] = '0;
            end
            step(p);
        end
        stepped = 1;
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle();
        do begin
            @(posedge clk); #1;
        end while (busy[0] || busy[1] || busy[2]);
        @(negedge clk); #1;
    endtask

    task automatic rd(logic [9:0] a);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();
    endtask

    task automatic expect_hit(int p, bit exp, string req);
        chk(last_hit[p] == exp, req, int'(last_hit[p]), int'(exp));
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin ack[p] = 1'b0; mline[p] = '0; end
        repeat (3) @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            chk(!busy[p] && !mreq[p] && !rv[p], "R1 idle in reset", int'(busy[p]), 0);
        end
        rst = 1'b0;

        // Empty set 1: first fill to way 0, second to the other empty way (R7)
        rd(mk(1, 1, 2));
        for (int p = 0; p < NP; p++) expect_hit(p, 0, "R1 first access misses");
        rd(mk(1, 1, 3));
        for (int p = 0; p < NP; p++) expect_hit(p, 1, "R3 hit after fill");
        rd(mk(2, 1, 0));
        rd(mk(1, 1, 0));
        for (int p = 0; p < NP; p++) expect_hit(p, 1, "R7 first line kept");
        rd(mk(2, 1, 1));
        for (int p = 0; p < NP; p++) expect_hit(p, 1, "R7 second line present");
        rd(mk(1, 1, 2));     // LRU: way1 now least recent; FIFO pointer still at way0
        rd(mk(3, 1, 1));     // full-set miss
        rd(mk(1, 1, 3));
        expect_hit(0, 1, "R12 recently used line survives");
        expect_hit(1, 0, "R10 oldest fill evicted");

        // LRU: hit C, miss D evicts A; FIFO: D evicts C
        rd(mk(3, 1, 0));
        rd(mk(4, 1, 3));
        rd(mk(3, 1, 2));
        expect_hit(0, 1, "R11 hit refreshed its line");
        expect_hit(1, 0, "R10 fills replaced in turn");
        rd(mk(1, 1, 1));
        expect_hit(0, 0, "R11 other way became victim");
        expect_hit(1, 0, "R10 pointer alternates");

        // Request while busy is dropped (R6)
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = mk(5, 2, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = mk(6, 3, 1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();
        rd(mk(6, 3, 1));
        for (int p = 0; p < NP; p++) expect_hit(p, 0, "R6 ignored request filled nothing");

        // Back-to-back hits (R3)
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = mk(5, 2, 1);
        @(posedge clk); #1;
        req_addr = mk(5, 2, 3);
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();

        // Conflict sweep exercising all policies, including random (R9) and R8 refills
        for (int i = 0; i < 80; i++) rd(mk((i * 3) % 5, (i * 7) % 4, i % 4));
        for (int i = 0; i < 40; i++) rd(mk((i * 5 + 1) % 3, 0, (i + 1) % 4));

        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R4 watchdog expired act=1 exp=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule